// File: doc/BRIEF.md
# Time-Slot Schedule Gate

This block splits link time into a fixed ring of numbered slots and decides, slot by slot, which virtual channels may take part in link arbitration. A schedule table holds one row per slot. Each row is a bit mask with one bit per channel. When a slot begins, the row for that slot is captured into a mask register. The mask is ANDed with the arbiter's own per-channel eligibility vector. The arbiter then picks among the survivors on priority and bandwidth credit. Several channels may share a slot, so a low-priority channel can use a slot whenever the critical channel in that slot has nothing ready.

There are two ways to decide when a slot begins. In broadcast mode, an incoming start-of-slot pulse carries a slot number, and that number is loaded directly. In local mode, a cycle counter measures out a programmed slot length in clock cycles and then advances the slot number by one, wrapping after the last slot. The schedule is always in force. After reset every row enables every channel, which gives plain precedence-based operation until software loads a real schedule through the table write port.

Top module: `slot_sched_gate`

## Requirements
- R1: After reset, `cur_slot` is 0, `slot_mask` is all ones, `slot_start` is 0, every table row holds all ones, and the slot length is `RST_LEN` clocks.
- R2: With the default `REG_GRANT` = 0, `grant` equals `arb_elig & slot_mask` combinationally. With `REG_GRANT` = 1, the same value appears one cycle later.
- R3: When `mode_local` is 0, a clock edge that samples `sos_pulse` high loads `sos_slot` into `cur_slot`. At that edge `slot_mask` takes the table row for that slot, and `slot_start` is 1 for the following cycle.
- R4: When `mode_local` is 0 and `sos_pulse` is low, `cur_slot` and `slot_mask` hold their values however long the wait.
- R5: When `mode_local` is 1 and the slot length is L ≥ 1, each slot lasts exactly L clock cycles. At the end of a slot `cur_slot` increases by one, and `slot_start` is 1 during the first cycle of the new slot.
- R6: In local mode, the slot after `NUM_SLOTS-1` is slot 0.
- R7: When `mode_local` is 1, `sos_pulse` and `sos_slot` have no effect on `cur_slot` or `slot_start`.
- R8: A slot length of 0 behaves as a length of 1, so a new slot starts every cycle. If the length is lowered to a value at or below the cycles already spent in the current slot, that slot ends at the first edge that compares against the new length.
- R9: A write to the row of the current slot leaves `slot_mask` unchanged until the next slot boundary. The new content becomes visible when a boundary lands on that row, including a broadcast pulse that repeats the same slot number.
- R10: A table write and a slot boundary into the same row on the same edge put the newly written value into `slot_mask`.
- R11: A row never written since reset enables every channel, so `grant` follows `arb_elig` unchanged in that slot.
- R12: A clock edge that samples `len_we` high loads `len_val` as the slot length used by every later comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_local | input | 1 | 1: local slot timer, 0: broadcast start-of-slot pulses |
| sos_pulse | input | 1 | Start-of-slot pulse from the broadcast receiver |
| sos_slot | input | SLOT_W | Slot number carried by the pulse |
| tbl_we | input | 1 | Table row write strobe |
| tbl_row | input | SLOT_W | Row (slot number) to write |
| tbl_mask | input | NUM_VC | Channel enable bits for that row |
| len_we | input | 1 | Slot length write strobe |
| len_val | input | LEN_W | Slot length in clock cycles |
| arb_elig | input | NUM_VC | Per-channel eligibility from the arbiter |
| grant | output | NUM_VC | Eligibility gated by the current slot mask |
| slot_mask | output | NUM_VC | Channel mask of the current slot |
| cur_slot | output | SLOT_W | Current slot number |
| slot_start | output | 1 | High in the first cycle of each slot |

## Verification
The bench goes after the edges where the timing of the mask register matters. These include a write to the live row, which a design without a held mask would let leak into the slot at once. They also include a write that lands on the same edge as a boundary into that row, where a design without the forwarding path would present the stale row. The slot-length corners are a length of zero, which a naive compare-to-length-minus-one would turn into a run of about 2^LEN_W cycles, and a length lowered below the count already spent, which an equality compare would miss until the counter wrapped. It also checks the wrap from the last slot back to zero, and confirms that broadcast pulses arriving in local mode do not disturb the slot number.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

   // source of slot boundaries
   typedef enum logic {
      SRC_BCAST = 1'b0,
      SRC_TIMER = 1'b1
   } slot_src_e;

   // default geometry
   localparam int unsigned DEF_NUM_VC    = 8;
   localparam int unsigned DEF_NUM_SLOTS = 256;
   localparam int unsigned DEF_LEN_W     = 16;
   // 100 us at 125 MHz
   localparam int unsigned DEF_RST_LEN   = 12500;

endpackage

// File: rtl/slot_timer.sv
module slot_timer
   import slot_sched_pkg::*;
#(
   parameter int unsigned SLOT_W  = 8,
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned RST_LEN = 12500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slot_src_e         src,
   input  logic              sos_pulse,
   input  logic [SLOT_W-1:0] sos_slot,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [SLOT_W-1:0] nxt_slot,
   output logic              bnd
);

   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  last_cnt;
   logic              hit;
   logic [SLOT_W-1:0] slot_q;

   // a programmed length of zero acts as one cycle
   assign last_cnt = (len_q == '0) ? '0 : len_q - 1'b1;
   // >= so that a shortened length ends the slot at once
   assign hit      = (src == SRC_TIMER) && (cnt_q >= last_cnt);
   assign bnd      = (src == SRC_TIMER) ? hit : sos_pulse;
   assign nxt_slot = (src == SRC_TIMER) ? slot_q + 1'b1 : sos_slot;
   assign cur_slot = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= LEN_W'(RST_LEN);
      end else if (len_we) begin
         len_q <= len_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (src != SRC_TIMER || hit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (bnd) begin
         slot_q <= nxt_slot;
      end
   end

endmodule

// File: rtl/slot_table.sv
module slot_table #(
   parameter int unsigned NUM_VC    = 8,
   parameter int unsigned NUM_SLOTS = 256,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_row,
   input  logic [NUM_VC-1:0] wr_mask,
   input  logic [SLOT_W-1:0] rd_row,
   output logic [NUM_VC-1:0] rd_mask
);

   logic [NUM_VC-1:0] rows [NUM_SLOTS];

   for (genvar r = 0; r < NUM_SLOTS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rows[r] <= '1;
         end else if (wr_en && wr_row == SLOT_W'(r)) begin
            rows[r] <= wr_mask;
         end
      end
   end

   // forward a write that targets the row being fetched on the same edge
   assign rd_mask = (wr_en && wr_row == rd_row) ? wr_mask : rows[rd_row];

endmodule

// File: rtl/slot_gate.sv
module slot_gate #(
   parameter int unsigned NUM_VC    = 8,
   parameter bit          REG_GRANT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bnd,
   input  logic [NUM_VC-1:0] row_mask,
   input  logic [NUM_VC-1:0] arb_elig,
   output logic [NUM_VC-1:0] mask,
   output logic              start,
   output logic [NUM_VC-1:0] grant
);

   logic [NUM_VC-1:0] mask_q;
   logic              start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         start_q <= 1'b0;
      end else begin
         start_q <= bnd;
         if (bnd) begin
            mask_q <= row_mask;
         end
      end
   end

   assign mask  = mask_q;
   assign start = start_q;

   if (REG_GRANT) begin : g_reg_grant
      logic [NUM_VC-1:0] grant_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grant_q <= '0;
         end else begin
            grant_q <= arb_elig & mask_q;
         end
      end
      assign grant = grant_q;
   end else begin : g_comb_grant
      assign grant = arb_elig & mask_q;
   end

endmodule

// File: rtl/slot_sched_gate.sv
module slot_sched_gate
   import slot_sched_pkg::*;
#(
   parameter int unsigned NUM_VC    = DEF_NUM_VC,
   parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
   parameter int unsigned LEN_W     = DEF_LEN_W,
   parameter int unsigned RST_LEN   = DEF_RST_LEN,
   parameter bit          REG_GRANT = 1'b0,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_local,
   input  logic              sos_pulse,
   input  logic [SLOT_W-1:0] sos_slot,
   input  logic              tbl_we,
   input  logic [SLOT_W-1:0] tbl_row,
   input  logic [NUM_VC-1:0] tbl_mask,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   input  logic [NUM_VC-1:0] arb_elig,
   output logic [NUM_VC-1:0] grant,
   output logic [NUM_VC-1:0] slot_mask,
   output logic [SLOT_W-1:0] cur_slot,
   output logic              slot_start
);

   // elaboration-time parameter checks
   if (NUM_VC < 1) begin : g_bad_vc
      $error("slot_sched_gate: NUM_VC must be at least 1");
   end
   if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("slot_sched_gate: NUM_SLOTS must be a power of two, at least 2");
   end
   if (LEN_W < 2 || LEN_W > 31) begin : g_bad_len_w
      $error("slot_sched_gate: LEN_W must lie in 2..31");
   end
   if (RST_LEN >= (1 << LEN_W)) begin : g_bad_rst_len
      $error("slot_sched_gate: RST_LEN does not fit in LEN_W bits");
   end

   slot_src_e         src;
   logic              bnd;
   logic [SLOT_W-1:0] nxt_slot;
   logic [NUM_VC-1:0] row_mask;

   assign src = mode_local ? SRC_TIMER : SRC_BCAST;

   slot_timer #(
      .SLOT_W  (SLOT_W),
      .LEN_W   (LEN_W),
      .RST_LEN (RST_LEN)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src),
      .sos_pulse (sos_pulse),
      .sos_slot  (sos_slot),
      .len_we    (len_we),
      .len_val   (len_val),
      .cur_slot  (cur_slot),
      .nxt_slot  (nxt_slot),
      .bnd       (bnd)
   );

   slot_table #(
      .NUM_VC    (NUM_VC),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_row  (tbl_row),
      .wr_mask (tbl_mask),
      .rd_row  (nxt_slot),
      .rd_mask (row_mask)
   );

   slot_gate #(
      .NUM_VC    (NUM_VC),
      .REG_GRANT (REG_GRANT)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .bnd      (bnd),
      .row_mask (row_mask),
      .arb_elig (arb_elig),
      .mask     (slot_mask),
      .start    (slot_start),
      .grant    (grant)
   );

endmodule

// File: rtl/slot_sched_gate_chk.sv
module slot_sched_gate_chk #(
   parameter int unsigned NUM_VC = 8,
   parameter int unsigned SLOT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_local,
   input logic              sos_pulse,
   input logic [SLOT_W-1:0] sos_slot,
   input logic [NUM_VC-1:0] slot_mask,
   input logic [SLOT_W-1:0] cur_slot,
   input logic              slot_start
);

   // R3
   ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_local && sos_pulse) |=> (cur_slot == $past(sos_slot) && slot_start));

   // R4
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_local && !sos_pulse) |=> ($stable(cur_slot) && !slot_start));

   // R5
   local_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_local |=> (slot_start ? (cur_slot == $past(cur_slot) + 1'b1)
                                 : (cur_slot == $past(cur_slot))));

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_start |-> $stable(slot_mask));

endmodule

bind slot_sched_gate slot_sched_gate_chk #(
   .NUM_VC (NUM_VC),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_local (mode_local),
   .sos_pulse  (sos_pulse),
   .sos_slot   (sos_slot),
   .slot_mask  (slot_mask),
   .cur_slot   (cur_slot),
   .slot_start (slot_start)
);

// File: tb/slot_sched_gate_tb.sv
module slot_sched_gate_tb;

   localparam int unsigned NV = 8;
   localparam int unsigned NS = 256;
   localparam int unsigned LW = 16;
   localparam int unsigned SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_local = 1'b0;
   logic          sos_pulse = 1'b0;
   logic [SW-1:0] sos_slot = '0;
   logic          tbl_we = 1'b0;
   logic [SW-1:0] tbl_row = '0;
   logic [NV-1:0] tbl_mask = '0;
   logic          len_we = 1'b0;
   logic [LW-1:0] len_val = '0;
   logic [NV-1:0] arb_elig = '1;
   logic [NV-1:0] grant;
   logic [NV-1:0] slot_mask;
   logic [SW-1:0] cur_slot;
   logic          slot_start;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   slot_sched_gate #(
      .NUM_VC    (NV),
      .NUM_SLOTS (NS),
      .LEN_W     (LW),
      .RST_LEN   (12500)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_local (mode_local),
      .sos_pulse  (sos_pulse),
      .sos_slot   (sos_slot),
      .tbl_we     (tbl_we),
      .tbl_row    (tbl_row),
      .tbl_mask   (tbl_mask),
      .len_we     (len_we),
      .len_val    (len_val),
      .arb_elig   (arb_elig),
      .grant      (grant),
      .slot_mask  (slot_mask),
      .cur_slot   (cur_slot),
      .slot_start (slot_start)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_row(input logic [SW-1:0] r, input logic [NV-1:0] m);
      @(negedge clk);
      tbl_we = 1'b1; tbl_row = r; tbl_mask = m;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic write_len(input logic [LW-1:0] l);
      len_we = 1'b1; len_val = l;
      @(negedge clk);
      len_we = 1'b0;
   endtask

   task automatic pulse(input logic [SW-1:0] s);
      @(negedge clk);
      sos_pulse = 1'b1; sos_slot = s;
      @(negedge clk);
      sos_pulse = 1'b0;
   endtask

   task automatic wait_start(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!slot_start && n < 2000);
   endtask

   task automatic t_reset;
      chk("R1 cur_slot", 32'(cur_slot), 0);
      chk("R1 slot_mask", 32'(slot_mask), 32'hFF);
      chk("R1 slot_start", 32'(slot_start), 0);
      // R11: unwritten rows pass everything
      chk("R11 grant", 32'(grant), 32'hFF);
   endtask

   task automatic t_ext_load;
      write_row(8'd5, 8'h0A);
      pulse(8'd5);
      chk("R3 cur_slot", 32'(cur_slot), 5);
      chk("R3 slot_mask", 32'(slot_mask), 32'h0A);
      chk("R3 slot_start", 32'(slot_start), 1);
      chk("R2 grant all", 32'(grant), 32'h0A);
      arb_elig = 8'h08; #1;
      chk("R2 grant part", 32'(grant), 32'h08);
      arb_elig = 8'hF5; #1;
      chk("R2 grant none", 32'(grant), 32'h00);
      arb_elig = '1;
      @(negedge clk);
      chk("R3 start one cycle", 32'(slot_start), 0);
   endtask

   task automatic t_hold;
      repeat (40) @(negedge clk);
      chk("R4 cur_slot", 32'(cur_slot), 5);
      chk("R4 slot_mask", 32'(slot_mask), 32'h0A);
   endtask

   task automatic t_live_row;
      write_row(8'd5, 8'h30);
      chk("R9 mask held", 32'(slot_mask), 32'h0A);
      repeat (3) @(negedge clk);
      chk("R9 mask still held", 32'(slot_mask), 32'h0A);
      pulse(8'd5);
      chk("R9 mask after reentry", 32'(slot_mask), 32'h30);
   endtask

   task automatic t_bypass;
      @(negedge clk);
      tbl_we = 1'b1; tbl_row = 8'd7; tbl_mask = 8'h41;
      sos_pulse = 1'b1; sos_slot = 8'd7;
      @(negedge clk);
      tbl_we = 1'b0; sos_pulse = 1'b0;
      chk("R10 cur_slot", 32'(cur_slot), 7);
      chk("R10 slot_mask", 32'(slot_mask), 32'h41);
   endtask

   task automatic t_unsched;
      pulse(8'd200);
      chk("R11 slot_mask", 32'(slot_mask), 32'hFF);
      arb_elig = 8'h5C; #1;
      chk("R11 grant", 32'(grant), 32'h5C);
      arb_elig = '1;
   endtask

   task automatic t_local_period;
      int n;
      logic [SW-1:0] s;
      @(negedge clk);
      write_len(16'd5);
      mode_local = 1'b1;
      wait_start(n);
      s = cur_slot;
      wait_start(n);
      chk("R5 R12 period", 32'(n), 5);
      chk("R5 increment", 32'(cur_slot), 32'(SW'(s + 1'b1)));
      wait_start(n);
      chk("R5 period again", 32'(n), 5);
   endtask

   task automatic t_ignore;
      int n;
      logic [SW-1:0] s;
      wait_start(n);
      write_len(16'd1000);
      s = cur_slot;
      sos_pulse = 1'b1; sos_slot = 8'd99;
      @(negedge clk);
      sos_pulse = 1'b0;
      chk("R7 cur_slot", 32'(cur_slot), 32'(s));
      chk("R7 slot_start", 32'(slot_start), 0);
   endtask

   task automatic t_shrink;
      int n;
      repeat (20) @(negedge clk);
      len_we = 1'b1; len_val = 16'd3;
      @(negedge clk);
      len_we = 1'b0;
      chk("R8 no early end", 32'(slot_start), 0);
      @(negedge clk);
      chk("R8 shortened end", 32'(slot_start), 1);
      wait_start(n);
      chk("R8 R12 new period", 32'(n), 3);
   endtask

   task automatic t_zero;
      logic [SW-1:0] s;
      write_len(16'd0);
      repeat (3) @(negedge clk);
      s = cur_slot;
      @(negedge clk);
      chk("R8 zero len start", 32'(slot_start), 1);
      chk("R8 zero len step", 32'(cur_slot), 32'(SW'(s + 1'b1)));
   endtask

   task automatic t_wrap;
      int n = 0;
      while (cur_slot != 8'd255 && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk("R6 reached last", 32'(cur_slot), 255);
      @(negedge clk);
      chk("R6 wrap", 32'(cur_slot), 0);
   endtask

   task automatic t_back_to_ext;
      logic [SW-1:0] s;
      mode_local = 1'b0;
      @(negedge clk);
      s = cur_slot;
      repeat (10) @(negedge clk);
      chk("R4 hold after mode change", 32'(cur_slot), 32'(s));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ext_load();
      t_hold();
      t_live_row();
      t_bypass();
      t_unsched();
      t_local_period();
      t_ignore();
      t_shrink();
      t_zero();
      t_wrap();
      t_back_to_ext();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule